// File: doc/BRIEF.md
# Control Register Move Unit

This block carries out privileged moves to and from a small set of processor control registers: the machine-control register (slot 0), the fault-address register (slot 2), the page-table base register (slot 3), the feature-enable register (slot 4) and the task-priority register (slot 8). Each request names a slot with a 4-bit index and says whether it is a read or a write. It also carries the write value, the current privilege level and a long-mode flag. One cycle later the block returns a registered response. The response gives a fault flag and any read data.

On a write, the block applies each register's own rules. Some illegal values raise a fault. Some reserved bits are dropped without a fault, and one bit always reads as 1. When a write succeeds, the block pulses strobes that the translation buffers and the page walker use: a flush of non-global entries, a flush of all entries, and a reload of the page-pointer table. A faulting request changes no register and pulses no strobe.

Top module: `ctlreg_move_unit`

## Requirements
- R1: Any read or write with `cur_priv` not equal to 0 faults.
- R2: A slot-0 write whose value has bit 31 (paging) set and bit 0 (protection) clear faults.
- R3: A slot-0 write whose value has bit 29 (no-write-through) set and bit 30 (cache disable) clear faults.
- R4: A slot-4 write with a 1 in any bit above bit 10 faults.
- R5: Slot 0 keeps only bits 0-3, 5, 16, 18 and 29-31, and bit 4 always reads 1. Slot 3 reads bits 0-2 and 5-11 as 0. Slot 8 keeps only bits 3:0. None of these dropped bits causes a fault.
- R6: Every successful slot-3 write pulses `flush_local` in the response cycle.
- R7: A successful write pulses `flush_all` when it changes slot-0 bit 0 or bit 31, or slot-4 bit 4, 5 or 7. Otherwise `flush_all` stays low.
- R8: `ptr_reload` pulses on a successful write when, after that write, slot-0 bit 31 and slot-4 bit 5 are both 1, and the write is one of the following: a slot-3 write, a slot-4 write that takes bit 5 from 0 to 1, or a slot-0 write that takes bit 31 from 0 to 1.
- R9: With `long_mode` set, a slot-4 write whose value has bit 5 clear faults.
- R10: A faulting request leaves every register unchanged and pulses no strobe.
- R11: With `long_mode` clear, bits 63:32 of the write value are ignored and reads return bits 63:32 as 0. With `long_mode` set, all 64 bits are used.
- R12: An index other than 0, 2, 3, 4 or 8 faults.
- R13: `rsp_valid` pulses exactly one cycle after each request. `rsp_rdata` is 0 for writes and for faults. After reset, slot 0 holds 0x60000010 and all other slots hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 4 | Control-register slot index |
| req_wdata | input | XLEN | Write value |
| cur_priv | input | 2 | Current privilege level |
| long_mode | input | 1 | Wide (64-bit) operation |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Request faulted |
| rsp_rdata | output | XLEN | Read data |
| flush_local | output | 1 | Flush non-global translations |
| flush_all | output | 1 | Flush every translation |
| ptr_reload | output | 1 | Reload the page-pointer table |

## Verification
Some rules are checked by assertions on every cycle. Stored register state must never hold paging without protection or no-write-through without cache disable. Bit 4 of slot 0 must stay 1, and the reserved feature bits must stay 0. Privilege faults, bad-index faults, the slot-3 flush and strobe silence on faults are also checked each cycle, as is the one-cycle response timing. Other behaviour needs the bench's scenarios against its reference model. That covers which bits are dropped, the narrow-mode truncation, the exact conditions for the full flush and for the pointer reload, and the fact that a faulting write leaves the registers unchanged.

// File: rtl/crg_pkg.sv
package crg_pkg;
  localparam int unsigned CRG_IDX_W = 4;

  typedef enum logic [CRG_IDX_W-1:0] {
    SLOT_MCTL  = 4'd0,
    SLOT_FADDR = 4'd2,
    SLOT_PTBR  = 4'd3,
    SLOT_FEAT  = 4'd4,
    SLOT_TPRI  = 4'd8
  } crg_slot_e;

  // machine-control bit positions
  localparam int unsigned B_PROT  = 0;
  localparam int unsigned B_EXT   = 4;
  localparam int unsigned B_NOWT  = 29;
  localparam int unsigned B_CDIS  = 30;
  localparam int unsigned B_PAGE  = 31;
  // feature-enable bit positions
  localparam int unsigned B_BIGPG = 4;
  localparam int unsigned B_ADRX  = 5;
  localparam int unsigned B_GLOB  = 7;
  localparam int unsigned FEAT_DEF_W = 11;
  localparam int unsigned TPRI_W     = 4;

  localparam logic [31:0] MCTL_KEEP_LO  = 32'hE005_002F;
  localparam logic [11:0] PTBR_DROP_LO  = 12'hFE7;
  localparam logic [31:0] MCTL_RESET_LO = 32'h6000_0010;

  typedef struct packed {
    logic prot;
    logic page;
    logic bigpg;
    logic adrx;
    logic glob;
  } crg_pgflags_t;

  typedef struct packed {
    logic flush_local;
    logic flush_all;
    logic reload;
  } crg_fx_t;
endpackage

// File: rtl/crg_write_check.sv
module crg_write_check
  import crg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                 req_write,
  input  logic [CRG_IDX_W-1:0] req_idx,
  input  logic [XLEN-1:0]      req_wdata,
  input  logic [1:0]           cur_priv,
  input  logic                 long_mode,
  output logic                 fault,
  output logic [XLEN-1:0]      wval
);
  localparam logic [XLEN-1:0] MCTL_KEEP = XLEN'(MCTL_KEEP_LO);
  localparam logic [XLEN-1:0] EXT_ONE   = XLEN'(1) << B_EXT;
  localparam logic [XLEN-1:0] PTBR_KEEP = ~XLEN'(PTBR_DROP_LO);
  localparam logic [XLEN-1:0] FEAT_DEF  = {{(XLEN-FEAT_DEF_W){1'b0}}, {FEAT_DEF_W{1'b1}}};
  localparam logic [XLEN-1:0] TPRI_KEEP = {{(XLEN-TPRI_W){1'b0}}, {TPRI_W{1'b1}}};

  logic [XLEN-1:0] wide;
  logic            idx_ok;
  logic            val_bad;

  always_comb begin
    wide = long_mode ? req_wdata
                     : {{(XLEN-NARROW_W){1'b0}}, req_wdata[NARROW_W-1:0]};
    idx_ok  = 1'b1;
    val_bad = 1'b0;
    wval    = wide;
    case (req_idx)
      SLOT_MCTL: begin
        wval    = (wide & MCTL_KEEP) | EXT_ONE;
        val_bad = (wval[B_PAGE] & ~wval[B_PROT]) | (wval[B_NOWT] & ~wval[B_CDIS]);
      end
      SLOT_FADDR: wval = wide;
      SLOT_PTBR:  wval = wide & PTBR_KEEP;
      SLOT_FEAT: begin
        wval    = wide;
        val_bad = ((wide & ~FEAT_DEF) != '0) | (long_mode & ~wide[B_ADRX]);
      end
      SLOT_TPRI:  wval = wide & TPRI_KEEP;
      default:    idx_ok = 1'b0;
    endcase
    fault = (cur_priv != 2'd0) | ~idx_ok | (req_write & val_bad);
  end
endmodule

// File: rtl/crg_effects.sv
module crg_effects
  import crg_pkg::*;
(
  input  logic                 wr_ok,
  input  logic [CRG_IDX_W-1:0] req_idx,
  input  crg_pgflags_t         old_fl,
  input  crg_pgflags_t         new_fl,
  output crg_fx_t              fx
);
  logic changed;
  logic rising;

  always_comb begin
    changed = (old_fl != new_fl);
    rising  = (new_fl.adrx & ~old_fl.adrx) | (new_fl.page & ~old_fl.page);
    fx.flush_local = wr_ok & (req_idx == SLOT_PTBR);
    fx.flush_all   = wr_ok & changed;
    fx.reload      = wr_ok & new_fl.page & new_fl.adrx &
                     ((req_idx == SLOT_PTBR) | rising);
  end
endmodule

// File: rtl/crg_bank.sv
module crg_bank
  import crg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [CRG_IDX_W-1:0] idx,
  input  logic [XLEN-1:0]      wval,
  input  logic                 long_mode,
  output logic [XLEN-1:0]      rdata,
  output crg_pgflags_t         flags
);
  logic [XLEN-1:0] mctl_q, faddr_q, ptbr_q, feat_q;
  logic [TPRI_W-1:0] tpri_q;
  logic [XLEN-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      mctl_q  <= XLEN'(MCTL_RESET_LO);
      faddr_q <= '0;
      ptbr_q  <= '0;
      feat_q  <= '0;
      tpri_q  <= '0;
    end else if (we) begin
      case (idx)
        SLOT_MCTL:  mctl_q  <= wval;
        SLOT_FADDR: faddr_q <= wval;
        SLOT_PTBR:  ptbr_q  <= wval;
        SLOT_FEAT:  feat_q  <= wval;
        SLOT_TPRI:  tpri_q  <= wval[TPRI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      SLOT_MCTL:  sel = mctl_q;
      SLOT_FADDR: sel = faddr_q;
      SLOT_PTBR:  sel = ptbr_q;
      SLOT_FEAT:  sel = feat_q;
      SLOT_TPRI:  sel = {{(XLEN-TPRI_W){1'b0}}, tpri_q};
      default:    sel = '0;
    endcase
    rdata = long_mode ? sel : {{(XLEN-NARROW_W){1'b0}}, sel[NARROW_W-1:0]};
    flags.prot  = mctl_q[B_PROT];
    flags.page  = mctl_q[B_PAGE];
    flags.bigpg = feat_q[B_BIGPG];
    flags.adrx  = feat_q[B_ADRX];
    flags.glob  = feat_q[B_GLOB];
  end

  assert_page_needs_prot_R2: assert property (@(posedge clk) disable iff (rst)
    !(mctl_q[B_PAGE] && !mctl_q[B_PROT]));
  assert_nowt_needs_cdis_R3: assert property (@(posedge clk) disable iff (rst)
    !(mctl_q[B_NOWT] && !mctl_q[B_CDIS]));
  assert_ext_bit_set_R5: assert property (@(posedge clk) disable iff (rst)
    mctl_q[B_EXT]);
  assert_feat_rsvd_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (feat_q >> FEAT_DEF_W) == '0);
endmodule

// File: rtl/ctlreg_move_unit.sv
module ctlreg_move_unit
  import crg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CRG_IDX_W-1:0] req_idx,
  input  logic [XLEN-1:0]      req_wdata,
  input  logic [1:0]           cur_priv,
  input  logic                 long_mode,
  output logic                 rsp_valid,
  output logic                 rsp_fault,
  output logic [XLEN-1:0]      rsp_rdata,
  output logic                 flush_local,
  output logic                 flush_all,
  output logic                 ptr_reload
);
  logic            chk_fault;
  logic [XLEN-1:0] wval;
  logic [XLEN-1:0] bank_rdata;
  logic            wr_ok;
  crg_pgflags_t    old_fl, new_fl;
  crg_fx_t         fx;

  crg_write_check #(.XLEN(XLEN), .NARROW_W(NARROW_W)) check_i (
    .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .cur_priv(cur_priv), .long_mode(long_mode),
    .fault(chk_fault), .wval(wval));

  assign wr_ok = req_valid & req_write & ~chk_fault;

  crg_bank #(.XLEN(XLEN), .NARROW_W(NARROW_W)) bank_i (
    .clk(clk), .rst(rst), .we(wr_ok), .idx(req_idx), .wval(wval),
    .long_mode(long_mode), .rdata(bank_rdata), .flags(old_fl));

  always_comb begin
    new_fl = old_fl;
    if (req_idx == SLOT_MCTL) begin
      new_fl.prot = wval[B_PROT];
      new_fl.page = wval[B_PAGE];
    end else if (req_idx == SLOT_FEAT) begin
      new_fl.bigpg = wval[B_BIGPG];
      new_fl.adrx  = wval[B_ADRX];
      new_fl.glob  = wval[B_GLOB];
    end
  end

  crg_effects fx_i (
    .wr_ok(wr_ok), .req_idx(req_idx), .old_fl(old_fl), .new_fl(new_fl), .fx(fx));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_rdata   <= '0;
      flush_local <= 1'b0;
      flush_all   <= 1'b0;
      ptr_reload  <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid & chk_fault;
      rsp_rdata   <= (req_valid & ~req_write & ~chk_fault) ? bank_rdata : '0;
      flush_local <= fx.flush_local;
      flush_all   <= fx.flush_all;
      ptr_reload  <= fx.reload;
    end
  end

  assert_priv_fault_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_priv != 2'd0) |=> rsp_fault);
  assert_ptbr_flush_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_idx == 4'd3 && cur_priv == 2'd0) |=> flush_local);
  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> !(flush_local || flush_all || ptr_reload));
  assert_bad_index_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(req_idx inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd8})) |=> rsp_fault);
  assert_resp_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_resp_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/ctlreg_move_unit_tb.sv
module ctlreg_move_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, long_mode;
  logic [3:0]  req_idx;
  logic [63:0] req_wdata;
  logic [1:0]  cur_priv;
  logic        rsp_valid, rsp_fault, flush_local, flush_all, ptr_reload;
  logic [63:0] rsp_rdata;

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [63:0] m_r0, m_r2, m_r3, m_r4, m_r8;

  always #2 clk = ~clk;

  ctlreg_move_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_wdata(req_wdata), .cur_priv(cur_priv),
    .long_mode(long_mode), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata), .flush_local(flush_local), .flush_all(flush_all),
    .ptr_reload(ptr_reload));

  task automatic compare(input string tag, input bit ev, input bit ef,
                         input logic [63:0] ed, input bit el, input bit ea, input bit er);
    total++;
    if (rsp_valid !== ev || rsp_fault !== ef || rsp_rdata !== ed ||
        flush_local !== el || flush_all !== ea || ptr_reload !== er) begin
      bad++;
      $display("FAIL %s: got v=%0b f=%0b d=%h l=%0b a=%0b r=%0b exp v=%0b f=%0b d=%h l=%0b a=%0b r=%0b",
               tag, rsp_valid, rsp_fault, rsp_rdata, flush_local, flush_all, ptr_reload,
               ev, ef, ed, el, ea, er);
    end
  endtask

  function automatic logic [63:0] mget(input int idx);
    case (idx)
      0: return m_r0;
      2: return m_r2;
      3: return m_r3;
      4: return m_r4;
      default: return m_r8;
    endcase
  endfunction

  // called at a falling edge; checks the response at the next one
  task automatic op(input bit wr, input int idx, input logic [63:0] d,
                    input int priv, input bit lm, input string tag);
    bit f, el, ea, er;
    logic [63:0] v, rd;
    bit opg, ope, oae, nope, nopg, noae, nbig, obig, nglb, oglb;
    req_valid = 1'b1; req_write = wr; req_idx = 4'(idx);
    req_wdata = d; cur_priv = 2'(priv); long_mode = lm;
    v  = lm ? d : {32'h0, d[31:0]};
    f  = (priv != 0) || !(idx == 0 || idx == 2 || idx == 3 || idx == 4 || idx == 8);
    el = 0; ea = 0; er = 0; rd = 64'h0;
    if (wr && !f) begin
      if (idx == 0) begin
        v = (v & 64'hE005_002F) | 64'h10;
        if (v[31] && !v[0]) f = 1;
        if (v[29] && !v[30]) f = 1;
      end else if (idx == 3) v = v & ~64'hFE7;
      else if (idx == 4) begin
        if ((v >> 11) != 0) f = 1;
        if (lm && !v[5]) f = 1;
      end else if (idx == 8) v = v & 64'hF;
    end
    if (!wr && !f) rd = lm ? mget(idx) : {32'h0, mget(idx) >> 32 == 0 ? mget(idx)[31:0] : mget(idx)[31:0]};
    if (wr && !f) begin
      ope = m_r0[0]; opg = m_r0[31]; oae = m_r4[5]; obig = m_r4[4]; oglb = m_r4[7];
      case (idx)
        0: m_r0 = v;
        2: m_r2 = v;
        3: m_r3 = v;
        4: m_r4 = v;
        default: m_r8 = v;
      endcase
      nope = m_r0[0]; nopg = m_r0[31]; noae = m_r4[5]; nbig = m_r4[4]; nglb = m_r4[7];
      el = (idx == 3);
      ea = (ope != nope) || (opg != nopg) || (oae != noae) || (obig != nbig) || (oglb != nglb);
      er = nopg && noae && (idx == 3 || (noae && !oae) || (nopg && !opg));
    end
    @(negedge clk);
    compare(tag, 1'b1, f, rd, el, ea, er);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    compare(tag, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R13 watchdog: got no finish exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_write = 0; req_idx = 0; req_wdata = 0;
    cur_priv = 0; long_mode = 0;
    m_r0 = 64'h6000_0010; m_r2 = 0; m_r3 = 0; m_r4 = 0; m_r8 = 0;
    repeat (3) @(negedge clk);
    compare("R13 reset outputs", 0, 0, 64'h0, 0, 0, 0);
    rst = 1'b0;
    op(0, 0, 0, 0, 0, "R13 reset value slot 0");
    op(0, 3, 0, 0, 0, "R13 reset value slot 3");
    idle("R13 idle");
    op(1, 0, 64'h11, 3, 0, "R1 priv write");
    op(0, 2, 0, 1, 0, "R1 priv read");
    op(0, 0, 0, 0, 0, "R10 unchanged after fault");
    op(1, 0, 64'h8000_0000, 0, 0, "R2 paging without protection");
    op(1, 0, 64'h2000_0001, 0, 0, "R3 nowt without cdis");
    op(0, 0, 0, 0, 0, "R10 slot 0 intact");
    op(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R11 R7 wide value narrow mode");
    op(0, 0, 0, 0, 0, "R5 slot 0 masked");
    op(1, 3, 64'hFFFF_FFFF, 0, 0, "R6 slot 3 flush");
    op(0, 3, 0, 0, 0, "R5 slot 3 masked");
    op(1, 4, 64'h800, 0, 0, "R4 feature reserved");
    op(1, 4, 64'h20, 0, 0, "R8 R7 addr ext set with paging");
    op(1, 3, 64'h1000, 0, 0, "R8 slot 3 reload");
    op(1, 4, 64'h20, 0, 0, "R7 no change no flush");
    op(1, 4, 64'h0, 0, 1, "R9 long mode clearing addr ext");
    op(1, 4, 64'h1_0000_0020, 0, 1, "R4 long mode upper reserved");
    op(0, 4, 0, 0, 0, "R10 slot 4 intact");
    op(1, 4, 64'hA0, 0, 1, "R7 global bit change");
    op(1, 2, 64'hDEAD_BEEF_0000_1234, 0, 1, "R11 wide write");
    op(0, 2, 0, 0, 1, "R11 wide read");
    op(0, 2, 0, 0, 0, "R11 narrow read");
    op(1, 1, 64'h5, 0, 0, "R12 bad index write");
    op(0, 9, 0, 0, 0, "R12 bad index read");
    op(1, 8, 64'hFF, 0, 0, "R5 slot 8 write");
    op(0, 8, 0, 0, 0, "R5 slot 8 masked");
    op(1, 0, 64'h6000_0011, 0, 0, "R7 paging off flush");
    op(1, 3, 64'h2000, 0, 0, "R8 no reload without paging");
    op(0, 0, 0, 0, 0, "R5 slot 0 ext bit");
    idle("R13 idle end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule